// File: doc/BRIEF.md
# Multiprocessor-Capable 9-Bit Serial Port

This block is an asynchronous serial port of the kind found beside small microcontroller cores. The CPU reaches it through two byte-wide registers. The first is a control/status register, which holds the frame format, the enables, both ninth bits and both completion flags. The second is a data buffer: writing it starts a transmission, and reading it returns the last accepted received byte. Frames have a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one high stop bit.

The port supports three frame formats. One is an 8-bit format at a variable rate. The other two are 9-bit formats, one at a fixed rate and one at a variable rate. The fixed rate comes from the system clock. The variable rate comes from an external baud tick. A doubling input doubles either rate.

The receiver oversamples each bit 16 times and takes a majority of three mid-bit samples. For multiprocessor networks it can drop every frame whose ninth bit is clear, so a node only wakes up for address frames. The transmit and receive completion flags are sticky. They are combined into one interrupt line.

Top module: `mpser_port`

## Requirements
- R1: After reset the control register reads 0x00, the data buffer reads 0x00, TXD is high and the interrupt is low.
- R2: With the format field (control bits 1:0) at 01, writing the data buffer sends a 10-bit frame on TXD: a low start bit, eight data bits LSB first, then a high stop bit.
- R3: With the format field at 10 or 11, the frame carries a ninth bit between the data and the stop bit, and that ninth bit equals control bit 4.
- R4: When a frame finishes transmitting, control bit 6 (transmit flag) sets and the interrupt goes high. Both stay set until software writes bit 6 as 0.
- R5: In format 01 with control bit 3 (receive enable) set, a received frame loads the data buffer, sets control bit 7 (receive flag) and stores the received stop bit in control bit 5.
- R6: In the 9-bit formats, the received ninth bit is stored in control bit 5.
- R7: While control bit 3 is clear, incoming frames leave the receive flag and the data buffer unchanged.
- R8: With control bit 2 (multiprocessor enable) set in a 9-bit format, a frame whose ninth bit is 0 is discarded. A frame whose ninth bit is 1 is accepted.
- R9: With control bit 2 set in format 01, a frame whose stop bit is 0 is discarded.
- R10: A frame that completes while the receive flag is still set is discarded. The data buffer keeps its earlier byte.
- R11: In format 10, one bit lasts 64 system clocks, or 32 clocks when the doubling input is high.
- R12: In formats 01 and 11, one bit lasts 32 baud ticks, or 16 baud ticks when the doubling input is high.
- R13: In format 00, a data-buffer write sends nothing and never sets the transmit flag, even after the format is changed to an active value.
- R14: A low pulse on RXD that is shorter than half a bit is rejected as a false start. A valid frame that follows it is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| buf_we | input | 1 | Data buffer write strobe, starts a transmission |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rdata | output | 8 | Last accepted received byte |
| baud_tick | input | 1 | One-cycle pulse setting the variable bit rate |
| dbl_rate | input | 1 | Doubles the bit rate when high |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | High while either completion flag is set |

## Verification
The transmitter is run with alternating, nibble-split and asymmetric data bytes, and with the ninth bit both set and clear. A swapped bit order or a wrong ninth-bit source then shows up as a wrong decoded word. The width of the low run at the start of a frame is measured in every rate setting, which separates the fixed divider from the tick divider and shows whether doubling takes effect. On the receive side, frames are sent with the ninth bit and the stop bit at each value, under each filter setting, with reception disabled and while the previous frame is still unread. A short glitch on the line, followed by a real frame, shows that false-start rejection works and leaves the receiver ready for the next frame.

// File: rtl/mpser_port.sv
`timescale 1ns/1ps
module mpser_port (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       buf_we,
  input  logic [7:0] buf_wdata,
  output logic [7:0] buf_rdata,
  input  logic       baud_tick,
  input  logic       dbl_rate,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  localparam logic [1:0] FMT_OFF = 2'b00;
  localparam logic [1:0] FMT_FIX = 2'b10;
  localparam logic [3:0] OS_LAST = 4'd15;
  localparam logic [3:0] VOTE_A  = 4'd7;
  localparam logic [3:0] VOTE_B  = 4'd8;
  localparam logic [3:0] VOTE_C  = 4'd9;

  logic [1:0] fmt;
  logic       mp_en, rx_en, tx_b8, rx_b8, tx_flag, rx_flag;
  logic [7:0] rbuf;

  wire nine   = fmt[1];
  wire fixed  = (fmt == FMT_FIX);
  wire active = (fmt != FMT_OFF);

  logic [1:0] pre;
  logic       os_tick;
  wire        adv = fixed | (active & baud_tick);

  always_comb begin
    if (fixed) os_tick = dbl_rate ? pre[0] : (pre == 2'b11);
    else       os_tick = adv & (dbl_rate | pre[0]);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pre <= 2'b00;
    else if (adv) pre <= pre + 2'd1;

  logic        tx_busy, tx_done;
  logic [3:0]  tx_os, tx_bit;
  logic [10:0] tx_sh;
  wire  [3:0]  tx_last = nine ? 4'd10 : 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_done <= 1'b0;
      tx_os   <= '0;
      tx_bit  <= '0;
      tx_sh   <= '1;
    end else begin
      tx_done <= 1'b0;
      if (!tx_busy) begin
        if (buf_we && active) begin
          tx_busy <= 1'b1;
          tx_os   <= '0;
          tx_bit  <= '0;
          tx_sh   <= {1'b1, nine ? tx_b8 : 1'b1, buf_wdata, 1'b0};
        end
      end else if (os_tick) begin
        tx_os <= tx_os + 4'd1;
        if (tx_os == OS_LAST) begin
          tx_sh  <= {1'b1, tx_sh[10:1]};
          tx_bit <= tx_bit + 4'd1;
          if (tx_bit == tx_last) begin
            tx_busy <= 1'b0;
            tx_done <= 1'b1;
          end
        end
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  logic       rx_s1, rx_s2, rx_prev, rx_busy, rx_nin;
  logic [3:0] rx_os, rx_bit;
  logic [1:0] vote;
  logic [7:0] rx_dat;
  wire  [3:0] rx_last = nine ? 4'd10 : 4'd9;
  wire        maj     = (vote[0] & vote[1]) | (vote[0] & rx_s2) | (vote[1] & rx_s2);
  wire        rx_fin  = rx_busy & os_tick & (rx_os == VOTE_C) & (rx_bit == rx_last);
  wire        ninth   = nine ? rx_nin : maj;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_prev <= 1'b1;
      rx_os   <= '0;
      rx_bit  <= '0;
      vote    <= '0;
      rx_dat  <= '0;
      rx_nin  <= 1'b0;
    end else if (os_tick) begin
      if (!rx_busy) begin
        rx_prev <= rx_s2;
        if (rx_en && rx_prev && !rx_s2) begin
          rx_busy <= 1'b1;
          rx_os   <= '0;
          rx_bit  <= '0;
        end
      end else begin
        rx_os <= rx_os + 4'd1;
        if (rx_os == VOTE_A) vote[0] <= rx_s2;
        if (rx_os == VOTE_B) vote[1] <= rx_s2;
        if (rx_os == OS_LAST) rx_bit <= rx_bit + 4'd1;
        if (rx_os == VOTE_C) begin
          if ((rx_bit == 4'd0 && maj) || rx_bit == rx_last) begin
            rx_busy <= 1'b0;
            rx_prev <= maj;
          end else if (rx_bit == 4'd9) begin
            rx_nin <= maj;
          end else if (rx_bit != 4'd0) begin
            rx_dat <= {maj, rx_dat[7:1]};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_flag, tx_flag, rx_b8, tx_b8, rx_en, mp_en, fmt} <= '0;
      rbuf <= '0;
    end else begin
      if (ctl_we) {rx_flag, tx_flag, rx_b8, tx_b8, rx_en, mp_en, fmt} <= ctl_wdata;
      if (tx_done) tx_flag <= 1'b1;
      if (rx_fin && !rx_flag && (!mp_en || ninth)) begin
        rx_flag <= 1'b1;
        rx_b8   <= ninth;
        rbuf    <= rx_dat;
      end
    end
  end

  assign ctl_rdata = {rx_flag, tx_flag, rx_b8, tx_b8, rx_en, mp_en, fmt};
  assign buf_rdata = rbuf;
  assign irq       = tx_flag | rx_flag;
endmodule

// File: rtl/mpser_port_chk.sv
`timescale 1ns/1ps
module mpser_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic       buf_we,
  input logic       txd,
  input logic [7:0] ctl_rdata,
  input logic [7:0] buf_rdata
);
  // R4
  tx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[6]) && !$past(ctl_we)) |-> ctl_rdata[6]);

  // R4
  tx_flag_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_rdata[6]) && !$past(ctl_we) && !$past(buf_we)) |-> txd);

  // R5
  rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[7]) && !$past(ctl_we)) |-> ctl_rdata[7]);

  // R10
  no_overrun_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_rdata[7]) |-> $stable(buf_rdata));

  // R13
  off_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctl_rdata[1:0] == 2'b00) && ctl_rdata[1:0] == 2'b00 && $past(txd)) |-> txd);
endmodule

bind mpser_port mpser_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .buf_we(buf_we),
  .txd(txd), .ctl_rdata(ctl_rdata), .buf_rdata(buf_rdata)
);

// File: tb/test_mpser_port.sv
`timescale 1ns/1ps
module test_mpser_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, buf_we = 1'b0;
  logic [7:0] ctl_wdata = '0, buf_wdata = '0;
  logic [7:0] ctl_rdata, buf_rdata;
  logic       baud_tick = 1'b0, dbl_rate = 1'b0, rxd = 1'b1;
  logic       txd, irq;
  int         checks = 0, failures = 0;
  int         bitp = 64;
  int         tick_div = 3;
  int         tick_cnt = 0;
  bit         done = 1'b0;

  mpser_port i_mpser_port (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .baud_tick(baud_tick), .dbl_rate(dbl_rate),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt  <= (tick_cnt == tick_div - 1) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == tick_div - 1);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wdata = v; buf_we = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wait_fall(output int t);
    t = 0;
    while (txd !== 1'b0 && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic get_tx(input bit has9, output logic [8:0] w, output logic st, output logic sb);
    int t;
    w = '0;
    wait_fall(t);
    repeat (bitp / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin repeat (bitp) @(negedge clk); w[i] = txd; end
    if (has9) begin repeat (bitp) @(negedge clk); w[8] = txd; end
    repeat (bitp) @(negedge clk);
    sb = txd;
    repeat (bitp) @(negedge clk);
  endtask

  task automatic low_run(output int n);
    int t;
    n = 0;
    wait_fall(t);
    while (txd === 1'b0 && n < 20000) begin @(negedge clk); n++; end
    repeat (6 * bitp) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit has9, input bit b9, input bit sv);
    @(negedge clk); rxd = 1'b0;
    repeat (bitp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bitp) @(negedge clk); end
    if (has9) begin rxd = b9; repeat (bitp) @(negedge clk); end
    rxd = sv; repeat (bitp) @(negedge clk);
    rxd = 1'b1; repeat (2 * bitp) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 buf", buf_rdata, 8'h00);
    chk("R1 txd", txd, 1);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_tx8;
    logic [8:0] w; logic st, sb;
    bitp = 96; dbl_rate = 1'b0;
    wr_ctl(8'h01);
    wr_buf(8'hA6);
    get_tx(1'b0, w, st, sb);
    chk("R2 start", st, 0);
    chk("R2 data", w[7:0], 8'hA6);
    chk("R2 stop", sb, 1);
  endtask

  task automatic t_tx9;
    logic [8:0] w; logic st, sb;
    bitp = 64; dbl_rate = 1'b0;
    wr_ctl(8'h12);
    wr_buf(8'h3C);
    get_tx(1'b1, w, st, sb);
    chk("R3 word b8=1", w, 9'h13C);
    chk("R3 stop", sb, 1);
    wr_ctl(8'h03);
    bitp = 96;
    wr_buf(8'hC5);
    get_tx(1'b1, w, st, sb);
    chk("R3 word b8=0", w, 9'h0C5);
  endtask

  task automatic t_txflag;
    logic [8:0] w; logic st, sb;
    bitp = 64; dbl_rate = 1'b0;
    wr_ctl(8'h02);
    chk("R4 flag clear before", ctl_rdata[6], 0);
    wr_buf(8'h81);
    get_tx(1'b1, w, st, sb);
    chk("R4 flag set", ctl_rdata[6], 1);
    chk("R4 irq set", irq, 1);
    repeat (500) @(negedge clk);
    chk("R4 flag held", ctl_rdata[6], 1);
    wr_ctl(8'h02);
    chk("R4 flag cleared", ctl_rdata[6], 0);
    chk("R4 irq cleared", irq, 0);
  endtask

  task automatic t_rates;
    int n;
    wr_ctl(8'h02);
    bitp = 64; dbl_rate = 1'b0;
    wr_buf(8'hF0); low_run(n);
    chk_rng("R11 fixed 64", n, 5 * 64 - 6, 5 * 64 + 2);
    dbl_rate = 1'b1; bitp = 32;
    wr_buf(8'hF0); low_run(n);
    chk_rng("R11 fixed 32", n, 5 * 32 - 6, 5 * 32 + 2);
    wr_ctl(8'h03);
    dbl_rate = 1'b0; bitp = 96;
    wr_buf(8'hF0); low_run(n);
    chk_rng("R12 var 32 ticks", n, 5 * 96 - 8, 5 * 96 + 2);
    dbl_rate = 1'b1; bitp = 48;
    wr_buf(8'hF0); low_run(n);
    chk_rng("R12 var 16 ticks", n, 5 * 48 - 8, 5 * 48 + 2);
    dbl_rate = 1'b0;
    wr_ctl(8'h00);
  endtask

  task automatic t_off;
    int lows;
    lows = 0;
    wr_ctl(8'h00);
    wr_buf(8'hA5);
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    wr_ctl(8'h02);
    for (int i = 0; i < 1500; i++) begin @(negedge clk); if (txd !== 1'b1) lows++; end
    chk("R13 no frame", lows, 0);
    chk("R13 no flag", ctl_rdata[6], 0);
  endtask

  task automatic t_rx8;
    bitp = 96; dbl_rate = 1'b0;
    wr_ctl(8'h09);
    send_rx(8'h5B, 1'b0, 1'b0, 1'b1);
    chk("R5 flag", ctl_rdata[7], 1);
    chk("R5 data", buf_rdata, 8'h5B);
    chk("R5 stop in bit5", ctl_rdata[5], 1);
  endtask

  task automatic t_rx9;
    bitp = 64;
    wr_ctl(8'h0A);
    send_rx(8'hE1, 1'b1, 1'b1, 1'b1);
    chk("R6 data", buf_rdata, 8'hE1);
    chk("R6 ninth=1", ctl_rdata[5], 1);
    wr_ctl(8'h0A);
    send_rx(8'h1E, 1'b1, 1'b0, 1'b1);
    chk("R6 ninth=0", ctl_rdata[5], 0);
    chk("R6 flag", ctl_rdata[7], 1);
  endtask

  task automatic t_rxoff;
    bitp = 64;
    wr_ctl(8'h02);
    send_rx(8'h77, 1'b1, 1'b1, 1'b1);
    chk("R7 no flag", ctl_rdata[7], 0);
    chk("R7 buf kept", buf_rdata, 8'h1E);
  endtask

  task automatic t_mp9;
    bitp = 64;
    wr_ctl(8'h0E);
    send_rx(8'h42, 1'b1, 1'b0, 1'b1);
    chk("R8 data frame dropped", ctl_rdata[7], 0);
    chk("R8 buf kept", buf_rdata, 8'h1E);
    send_rx(8'h99, 1'b1, 1'b1, 1'b1);
    chk("R8 address accepted", ctl_rdata[7], 1);
    chk("R8 address data", buf_rdata, 8'h99);
  endtask

  task automatic t_mp8;
    bitp = 96;
    wr_ctl(8'h0D);
    send_rx(8'h24, 1'b0, 1'b0, 1'b0);
    chk("R9 bad stop dropped", ctl_rdata[7], 0);
    send_rx(8'h6D, 1'b0, 1'b0, 1'b1);
    chk("R9 good stop accepted", ctl_rdata[7], 1);
    chk("R9 data", buf_rdata, 8'h6D);
  endtask

  task automatic t_overrun;
    bitp = 64;
    wr_ctl(8'h0A);
    send_rx(8'h11, 1'b1, 1'b0, 1'b1);
    send_rx(8'h22, 1'b1, 1'b1, 1'b1);
    chk("R10 buf kept", buf_rdata, 8'h11);
    chk("R10 ninth kept", ctl_rdata[5], 0);
    chk("R10 flag", ctl_rdata[7], 1);
  endtask

  task automatic t_false_start;
    bitp = 64;
    wr_ctl(8'h0A);
    @(negedge clk); rxd = 1'b0;
    repeat (bitp / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * bitp) @(negedge clk);
    chk("R14 glitch ignored", ctl_rdata[7], 0);
    send_rx(8'hB4, 1'b1, 1'b1, 1'b1);
    chk("R14 next frame flag", ctl_rdata[7], 1);
    chk("R14 next frame data", buf_rdata, 8'hB4);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx8();
    t_tx9();
    t_txflag();
    t_rates();
    t_off();
    t_rx8();
    t_rx9();
    t_rxoff();
    t_mp9();
    t_mp8();
    t_overrun();
    t_false_start();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule